// File: doc/BRIEF.md
# Two-Level Cache Latency Accumulator

This block is a tag-only timing model of a small two-level cache hierarchy. A stream of byte addresses is presented one per strobe. For each address the block decides whether the access is served by the first level, by the second level, or by main memory. It updates both tag directories and adds the access's latency to a running total. No data is stored and nothing is written. Main memory always responds, with a fixed cost.

The first level is fully associative: four ways of 256-byte lines, with age-based least-recently-used replacement. The second level is direct-mapped: four sets of 1024-byte lines. The two levels are filled independently, so a line may stay in the first level after the second level has dropped it. All results are registered and appear one cycle after the strobe.

Top module: `cache_lat_acc`

## Requirements
- R1: While rst_ni is low, and after it is released, l1_hit_o, l2_hit_o, lat_o and total_o are all zero.
- R2: An address whose line tag (addr_i[31:8]) matches a valid first-level way is a first-level hit. It gives l1_hit_o=1, l2_hit_o=0 and lat_o=1.
- R3: A first-level miss whose second-level entry at set addr_i[11:10] is valid and holds tag addr_i[31:12] gives l1_hit_o=0, l2_hit_o=1 and lat_o=11. The line is then loaded into the first level.
- R4: A miss at both levels gives l1_hit_o=0, l2_hit_o=0 and lat_o=1011. The line is loaded into both levels.
- R5: A first-level fill goes to the lowest-numbered invalid way. If every way is valid, it goes to the way with the largest age, and a tie goes to the lowest index. On every access, the accessed way's age becomes 0 and each other way's age rises by one, saturating at 255.
- R6: A second-level miss replaces whatever line occupied that set. A later access to the displaced line then misses in the second level.
- R7: Outputs change only at a clock edge where req_i is high. total_o then becomes the previous total plus the new lat_o. With req_i low, all outputs hold.
- R8: total_o saturates at its all-ones value (2^ACC_W-1) instead of wrapping.
- R9: The levels are not inclusive. A line evicted from the second level stays a first-level hit while it remains in the first level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe |
| addr_i | input | ADDR_W (32) | Byte address of the access |
| l1_hit_o | output | 1 | Last access hit the first level |
| l2_hit_o | output | 1 | Last access missed the first level and hit the second |
| lat_o | output | LAT_W (11) | Latency of the last access |
| total_o | output | ACC_W (32) | Saturating sum of all access latencies |

## Verification
A corrupted tag, valid bit or age in either directory does not show up at once. It appears as a wrong hit flag and latency on the next access that touches that line or set. Because of this, the stimulus revisits a small pool of lines, so stale state is read back within a few accesses. A wrong victim choice shows up as a first-level miss on a line that should still be resident. The total shows any single-cycle error permanently, so one wrong latency is never hidden. Saturation is exercised on a second instance that has a narrow accumulator.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic [1:0] {
    SRC_L1  = 2'd0,
    SRC_L2  = 2'd1,
    SRC_MEM = 2'd2
  } src_e;
endpackage

// File: rtl/cla_l1_dir.sv
module cla_l1_dir #(
  parameter int TAG_W = 24,
  parameter int WAYS  = 4,
  parameter int AGE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [WAYS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [AGE_W-1:0] age_q [WAYS];
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, vict_way, tgt_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == tag_i);
  end

  assign hit_o = |hit_vec;

  // victim: first invalid way, else oldest (ties -> lowest index)
  always_comb begin
    logic found_inv;
    logic [AGE_W-1:0] best;
    found_inv = 1'b0;
    vict_way  = '0;
    best      = age_q[0];
    hit_way   = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_way = WAY_W'(i);
      if (!vld_q[i] && !found_inv) begin
        found_inv = 1'b1;
        vict_way  = WAY_W'(i);
      end
    end
    if (!found_inv) begin
      for (int i = 1; i < WAYS; i++) begin
        if (age_q[i] > best) begin
          best     = age_q[i];
          vict_way = WAY_W'(i);
        end
      end
    end
  end

  assign tgt_way = hit_o ? hit_way : vict_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        age_q[g] <= '0;
      end else if (lookup_i) begin
        if (tgt_way == WAY_W'(g)) begin
          age_q[g] <= '0;
          if (!hit_o) begin
            vld_q[g] <= 1'b1;
            tag_q[g] <= tag_i;
          end
        end else if (age_q[g] != AGE_MAX) begin
          age_q[g] <= age_q[g] + 1'b1;
        end
      end
    end
  end

  AST_L1_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R2
  AST_L1_TOUCH_YOUNG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> vld_q[$past(tgt_way)] && age_q[$past(tgt_way)] == '0); // R5
endmodule

// File: rtl/cla_l2_dir.sv
module cla_l2_dir #(
  parameter int TAG_W = 20,
  parameter int SETS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lookup_i,
  input  logic [$clog2(SETS)-1:0] idx_i,
  input  logic [TAG_W-1:0]        tag_i,
  output logic                    hit_o
);
  localparam int IDX_W = $clog2(SETS);

  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];

  assign hit_o = vld_q[idx_i] && (tag_q[idx_i] == tag_i);

  for (genvar g = 0; g < SETS; g++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (lookup_i && !hit_o && idx_i == IDX_W'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= tag_i;
      end
    end
  end

  AST_L2_RESIDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> vld_q[$past(idx_i)] && tag_q[$past(idx_i)] == $past(tag_i)); // R6
endmodule

// File: rtl/cla_lat_acc.sv
module cla_lat_acc
  import cla_pkg::*;
#(
  parameter int LAT_W   = 11,
  parameter int ACC_W   = 32,
  parameter int L1_LAT  = 1,
  parameter int L2_LAT  = 10,
  parameter int MEM_LAT = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             l1_hit_i,
  input  logic             l2_hit_i,
  output logic             l1_hit_o,
  output logic             l2_hit_o,
  output logic [LAT_W-1:0] lat_o,
  output logic [ACC_W-1:0] total_o
);
  localparam int SUM_W = ACC_W + 1;
  localparam logic [LAT_W-1:0] LAT_A = LAT_W'(L1_LAT);
  localparam logic [LAT_W-1:0] LAT_B = LAT_W'(L1_LAT + L2_LAT);
  localparam logic [LAT_W-1:0] LAT_C = LAT_W'(L1_LAT + L2_LAT + MEM_LAT);

  src_e             src;
  logic [LAT_W-1:0] lat_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    if (l1_hit_i)      src = SRC_L1;
    else if (l2_hit_i) src = SRC_L2;
    else               src = SRC_MEM;
    unique case (src)
      SRC_L1:  lat_d = LAT_A;
      SRC_L2:  lat_d = LAT_B;
      default: lat_d = LAT_C;
    endcase
  end

  assign sum = {1'b0, total_o} + SUM_W'(lat_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_hit_o <= 1'b0;
      l2_hit_o <= 1'b0;
      lat_o    <= '0;
      total_o  <= '0;
    end else if (req_i) begin
      l1_hit_o <= (src == SRC_L1);
      l2_hit_o <= (src == SRC_L2);
      lat_o    <= lat_d;
      total_o  <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l1_hit_o && l2_hit_o)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(total_o) && $stable(lat_o)); // R7
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> total_o >= $past(total_o)); // R8
  AST_LAT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (l1_hit_o && lat_o == LAT_A) || (l2_hit_o && lat_o == LAT_B) ||
              (!l1_hit_o && !l2_hit_o && lat_o == LAT_C)); // R4
endmodule

// File: rtl/cache_lat_acc.sv
module cache_lat_acc #(
  parameter int ADDR_W   = 32,
  parameter int L1_LINE  = 256,
  parameter int L1_WAYS  = 4,
  parameter int L1_AGE_W = 8,
  parameter int L2_LINE  = 1024,
  parameter int L2_SETS  = 4,
  parameter int LAT_W    = 11,
  parameter int ACC_W    = 32,
  parameter int L1_LAT   = 1,
  parameter int L2_LAT   = 10,
  parameter int MEM_LAT  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              l1_hit_o,
  output logic              l2_hit_o,
  output logic [LAT_W-1:0]  lat_o,
  output logic [ACC_W-1:0]  total_o
);
  localparam int L1_OFF   = $clog2(L1_LINE);
  localparam int L1_TAG_W = ADDR_W - L1_OFF;
  localparam int L2_OFF   = $clog2(L2_LINE);
  localparam int L2_IDX_W = $clog2(L2_SETS);
  localparam int L2_TAG_W = ADDR_W - L2_OFF - L2_IDX_W;

  logic l1_hit, l2_hit;

  cla_l1_dir #(
    .TAG_W(L1_TAG_W), .WAYS(L1_WAYS), .AGE_W(L1_AGE_W)
  ) u_l1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lookup_i(req_i),
    .tag_i   (addr_i[ADDR_W-1:L1_OFF]),
    .hit_o   (l1_hit)
  );

  cla_l2_dir #(
    .TAG_W(L2_TAG_W), .SETS(L2_SETS)
  ) u_l2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lookup_i(req_i && !l1_hit),
    .idx_i   (addr_i[L2_OFF+L2_IDX_W-1:L2_OFF]),
    .tag_i   (addr_i[ADDR_W-1:L2_OFF+L2_IDX_W]),
    .hit_o   (l2_hit)
  );

  cla_lat_acc #(
    .LAT_W(LAT_W), .ACC_W(ACC_W),
    .L1_LAT(L1_LAT), .L2_LAT(L2_LAT), .MEM_LAT(MEM_LAT)
  ) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .l1_hit_i(l1_hit),
    .l2_hit_i(l2_hit),
    .l1_hit_o(l1_hit_o),
    .l2_hit_o(l2_hit_o),
    .lat_o   (lat_o),
    .total_o (total_o)
  );
endmodule

// File: tb/cache_lat_acc_tb_top.sv
module cache_lat_acc_tb_top;
  localparam int SAT_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        l1_hit, l2_hit, s_l1, s_l2;
  logic [10:0] lat, s_lat;
  logic [31:0] total;
  logic [SAT_W-1:0] s_total;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk; // 125 MHz

  cache_lat_acc dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .l1_hit_o(l1_hit), .l2_hit_o(l2_hit), .lat_o(lat), .total_o(total)
  );

  cache_lat_acc #(.ACC_W(SAT_W)) dut_sat_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .l1_hit_o(s_l1), .l2_hit_o(s_l2), .lat_o(s_lat), .total_o(s_total)
  );

  // behavioural reference model
  int     m_tag1 [4];
  bit     m_v1   [4];
  int     m_age  [4];
  int     m_tag2 [4];
  bit     m_v2   [4];
  bit     m_l1, m_l2;
  int     m_lat;
  longint m_total, m_sat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_v1[i] = 0; m_age[i] = 0; m_tag1[i] = 0; m_v2[i] = 0; m_tag2[i] = 0;
      end
      m_l1 = 0; m_l2 = 0; m_lat = 0; m_total = 0; m_sat = 0;
    end else if (req) begin
      int t1, t2, s2, w;
      t1 = int'(addr >> 8); s2 = int'((addr >> 10) & 3); t2 = int'(addr >> 12);
      w = -1;
      for (int i = 0; i < 4; i++) if (m_v1[i] && m_tag1[i] == t1) w = i;
      m_l1 = (w >= 0);
      m_l2 = 0;
      if (!m_l1) begin
        m_l2 = m_v2[s2] && m_tag2[s2] == t2;
        if (!m_l2) begin m_v2[s2] = 1; m_tag2[s2] = t2; end
        for (int i = 3; i >= 0; i--) if (!m_v1[i]) w = i;
        if (w < 0) begin
          w = 0;
          for (int i = 1; i < 4; i++) if (m_age[i] > m_age[w]) w = i;
        end
        m_v1[w] = 1; m_tag1[w] = t1;
      end
      for (int i = 0; i < 4; i++)
        if (i == w) m_age[i] = 0;
        else if (m_age[i] < 255) m_age[i]++;
      m_lat = m_l1 ? 1 : (m_l2 ? 11 : 1011);
      m_total = m_total + m_lat;
      if (m_total > 64'hFFFF_FFFF) m_total = 64'hFFFF_FFFF;
      m_sat = m_sat + m_lat;
      if (m_sat > (1 << SAT_W) - 1) m_sat = (1 << SAT_W) - 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string tg;
      tg = m_l1 ? "R2 outcome" : (m_l2 ? "R3 outcome" : "R4 outcome");
      chk(tg, {l1_hit, l2_hit, lat}, {m_l1, m_l2, 11'(m_lat)});
      chk("R7 total", total, m_total);
      chk("R8 narrow total", s_total, m_sat);
    end
  end

  task automatic acc(input logic [31:0] a, input bit e1, input bit e2, input string tag);
    @(negedge clk);
    req = 1'b1; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(tag, {l1_hit, l2_hit}, {e1, e2});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {l1_hit, l2_hit, lat, total}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {l1_hit, l2_hit, lat, total}, 0);

    acc(32'h0001, 0, 0, "R4 cold miss");
    chk("R4 lat", lat, 1011);
    acc(32'h0100, 0, 1, "R3 l2 hit");
    chk("R3 lat", lat, 11);
    acc(32'h0807, 0, 0, "R4 miss set2");
    acc(32'h0002, 1, 0, "R2 l1 hit");
    chk("R2 lat", lat, 1);
    acc(32'h0110, 1, 0, "R2 l1 hit way1");
    acc(32'h0907, 0, 1, "R3 l2 hit set2");
    acc(32'h0003, 1, 0, "R2 l1 hit");
    acc(32'h0120, 1, 0, "R2 l1 hit");
    acc(32'h1007, 0, 0, "R6 evicts set0 in l2");
    acc(32'h0004, 1, 0, "R9 l1 keeps line dropped by l2");
    acc(32'h0807, 0, 1, "R5 oldest way was replaced");
    acc(32'h0200, 0, 0, "R6 conflict miss in l2");
    chk("R7 running total", total, 4*1011 + 3*11 + 5*1);

    held = total;
    repeat (4) @(negedge clk);
    chk("R7 idle hold", total, held);

    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      req  = ($urandom % 4) != 0;
      addr = (($urandom % 24) << 8) | ($urandom % 256);
    end
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk("R8 saturated narrow total", s_total, (1 << SAT_W) - 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule